// File: doc/BRIEF.md
# Periodic-Reference Trigger Retimer

This block lives in the data-clock domain of each device that must act on a shared trigger. It keeps a programmable modulo counter whose zero count marks a periodic reference strobe. An alignment input restarts that counter so that several instances with the same period see the strobe on the same cycle. A trigger line shared by all devices is sampled through two synchronizer flops and a rising-edge detector. The first detected edge is held and is released as a one-cycle pulse only on the next reference strobe. The cycles that passed between detection and release are reported with the pulse. Every device therefore acts on the same clock cycle, even when the line reaches each one after a different delay.

One instance per system is made master. It launches the trigger with a send request, which drives the line high for a few cycles. The `STAR_MODE` parameter selects how the line is wired. In star wiring, output and input are separate pins, and the master's output pin is looped back to its own input. In bus wiring, one line carries both directions. The master then drives it through an output enable only while it sends, and reads it back like everyone else. A send request that cannot be served is refused and flagged.

The hold machine has two states. `HS_IDLE` waits for an edge. `HS_HELD` counts cycles until a strobe. Its transitions are *capture* (`HS_IDLE` to `HS_HELD` on a detected edge) and *release* (`HS_HELD` to `HS_IDLE` on a strobe). The launch machine also has two states. `TX_IDLE` is quiet and `TX_DRIVE` holds the line high. Its transitions are *launch* (`TX_IDLE` to `TX_DRIVE` on an accepted request) and *finish* (`TX_DRIVE` to `TX_IDLE` after the drive length).

Top module: `ptrig_retimer`

## Requirements
- R1: `ref_strobe` is high exactly in the cycles in which the internal counter is zero. After an alignment with period value P, the strobe repeats every P cycles. The strobe is high in the first cycle after reset.
- R2: When `align_i` is high at a clock edge, the strobe is high in the cycle that follows that edge, and the current `period_i` is taken at that edge. `align_i` has no synchronizer stage.
- R3: If `line_in` is first high in cycle c, the edge is detected in cycle c+2. It is released as a one-cycle `trig_sync` pulse in the cycle after the first strobe cycle that is strictly later than the detection cycle. If detection falls on a strobe cycle, the block waits a full period.
- R4: While `trig_sync` is high, `trig_lag` equals the strobe cycle minus the detection cycle. This value lies between 1 and P.
- R5: An edge detected while a previous edge is held, including one detected in the release cycle, is dropped and yields no pulse.
- R6: Only rising edges count. A line held high for many cycles gives exactly one trigger.
- R7: A `period_i` value of 0 or 1 is treated as 2.
- R8: A change of `period_i` does not shorten the running period. It is taken at the next counter wrap.
- R9: A send request from the master, sampled at edge e, drives `line_out` high from cycle e through cycle e+DRV_LEN-1, where DRV_LEN is `PULSE_LEN` raised to at least 3. In star wiring this edge is detected three cycles after the request edge minus one, like any other edge.
- R10: A send request is refused in any of three cases: the instance is not master, the instance is still driving, or (in star wiring) an edge is held. A refusal raises `send_refused` for the one cycle after the request edge and does not drive the line.
- R11: In star wiring `line_oe` follows `is_master`. In bus wiring it is high only while the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | Instance may launch the shared trigger |
| period_i | input | W | Strobe period in data-clock cycles |
| align_i | input | 1 | Restart the strobe counter at zero |
| send_req | input | 1 | Request to launch a trigger edge |
| line_in | input | 1 | Monitored trigger line (asynchronous) |
| line_out | output | 1 | Trigger value driven onto the line |
| line_oe | output | 1 | Output enable for `line_out` |
| ref_strobe | output | 1 | Periodic reference strobe |
| trig_sync | output | 1 | Retimed one-cycle trigger pulse |
| trig_lag | output | W | Cycles from detection to release, valid with `trig_sync` |
| send_refused | output | 1 | Pulse: the last send request was refused |

## Verification
Two things can land on the same clock cycle: a freshly detected edge and a reference strobe. A new edge can also land on the cycle in which a held edge is released. The bench places line rises at every phase of a known period after an alignment, including the phase where detection meets the strobe. It expects a full-period wait with a lag equal to P. It also places a second rise before a release and expects nothing from it. A scoreboard predicts each pulse's cycle and lag from the strobe grid. Any pulse that was not predicted, or that arrives early, late or with the wrong lag, is counted as a mismatch.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;
    typedef enum logic {
        HS_IDLE,
        HS_HELD
    } hold_st_t;

    typedef enum logic {
        TX_IDLE,
        TX_DRIVE
    } tx_st_t;
endpackage

// File: rtl/ptrig_ref_counter.sv
module ptrig_ref_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    input  logic         align_i,
    output logic         strobe
);
    localparam logic [W-1:0] MIN_PER = W'(2);

    logic [W-1:0] cnt;
    logic [W-1:0] per_q;
    logic [W-1:0] per_clamped;
    logic         wrap;

    always_comb begin
        per_clamped = (period_i < MIN_PER) ? MIN_PER : period_i;
        wrap        = (cnt >= per_q - W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            per_q <= per_clamped;
        end else if (align_i) begin
            cnt   <= '0;
            per_q <= per_clamped;
        end else if (wrap) begin
            cnt   <= '0;
            per_q <= per_clamped;
        end else begin
            cnt   <= cnt + W'(1);
        end
    end

    assign strobe = (cnt == '0);
endmodule

// File: rtl/ptrig_line_sync.sv
module ptrig_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], line_raw};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ptrig_hold_fsm.sv
module ptrig_hold_fsm
    import ptrig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    input  logic         strobe,
    output logic         trig_o,
    output logic [W-1:0] lag_o,
    output logic         pending
);
    hold_st_t     st, st_nx;
    logic [W-1:0] lag_cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            HS_IDLE: if (rise)   st_nx = HS_HELD;   // capture
            HS_HELD: if (strobe) st_nx = HS_IDLE;   // release
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= HS_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o  <= 1'b0;
            lag_o   <= '0;
            lag_cnt <= '0;
        end else begin
            trig_o <= (st == HS_HELD) && strobe;
            unique case (st)
                HS_IDLE: if (rise) lag_cnt <= W'(1);
                HS_HELD: begin
                    if (strobe) lag_o   <= lag_cnt;
                    else        lag_cnt <= lag_cnt + W'(1);
                end
            endcase
        end
    end

    assign pending = (st == HS_HELD);
endmodule

// File: rtl/ptrig_tx_fsm.sv
module ptrig_tx_fsm
    import ptrig_pkg::*;
#(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic req,
    input  logic block,
    output logic drive,
    output logic refused
);
    localparam int DRV_LEN = (PULSE_LEN < 3) ? 3 : PULSE_LEN;
    localparam int LW      = $clog2(DRV_LEN + 1);

    tx_st_t        st, st_nx;
    logic [LW-1:0] len_cnt;
    logic          accept;

    always_comb begin
        accept = req && is_master && (st == TX_IDLE) && !block;
        st_nx  = st;
        unique case (st)
            TX_IDLE:  if (accept) st_nx = TX_DRIVE;                       // launch
            TX_DRIVE: if (len_cnt == LW'(DRV_LEN - 1)) st_nx = TX_IDLE;    // finish
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_cnt <= '0;
            refused <= 1'b0;
        end else begin
            refused <= req && !accept;
            unique case (st)
                TX_IDLE:  len_cnt <= '0;
                TX_DRIVE: len_cnt <= len_cnt + LW'(1);
            endcase
        end
    end

    assign drive = (st == TX_DRIVE);
endmodule

// File: rtl/ptrig_retimer.sv
module ptrig_retimer #(
    parameter int W         = 8,
    parameter int STAGES    = 2,
    parameter int PULSE_LEN = 3,
    parameter bit STAR_MODE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_master,
    input  logic [W-1:0] period_i,
    input  logic         align_i,
    input  logic         send_req,
    input  logic         line_in,
    output logic         line_out,
    output logic         line_oe,
    output logic         ref_strobe,
    output logic         trig_sync,
    output logic [W-1:0] trig_lag,
    output logic         send_refused
);
    logic rise;
    logic pending;
    logic drive;
    logic block;

    ptrig_ref_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .period_i(period_i),
        .align_i(align_i), .strobe(ref_strobe)
    );

    ptrig_line_sync #(.STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .line_raw(line_in), .rise(rise)
    );

    ptrig_hold_fsm #(.W(W)) hold_i (
        .clk(clk), .rst_n(rst_n), .rise(rise), .strobe(ref_strobe),
        .trig_o(trig_sync), .lag_o(trig_lag), .pending(pending)
    );

    ptrig_tx_fsm #(.PULSE_LEN(PULSE_LEN)) tx_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .req(send_req),
        .block(block), .drive(drive), .refused(send_refused)
    );

    generate
        if (STAR_MODE) begin : g_star
            assign block   = pending;
            assign line_oe = is_master;
        end else begin : g_bus
            assign block   = 1'b0;
            assign line_oe = drive;
        end
    endgenerate

    assign line_out = drive;
endmodule

// File: rtl/ptrig_retimer_chk.sv
module ptrig_retimer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         align_i,
    input logic         ref_strobe,
    input logic         trig_sync,
    input logic [W-1:0] trig_lag,
    input logic         line_out,
    input logic         send_refused
);
    p_strobe_after_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        align_i |=> ref_strobe);

    p_strobe_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe && !align_i) |=> !ref_strobe);

    p_release_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_sync |-> $past(ref_strobe));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_sync |=> !trig_sync);

    p_lag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_sync |-> (trig_lag != '0));

    p_refuse_no_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        send_refused |-> !$rose(line_out));
endmodule

bind ptrig_retimer ptrig_retimer_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .align_i(align_i), .ref_strobe(ref_strobe),
    .trig_sync(trig_sync), .trig_lag(trig_lag), .line_out(line_out),
    .send_refused(send_refused)
);

// File: tb/ptrig_retimer_tb.sv
module ptrig_retimer_tb_top;
    localparam int CLK_PER = 10;
    localparam int W       = 8;

    typedef struct {
        int    cyc;
        int    lag;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         is_master = 1'b0;
    logic [W-1:0] period_i = W'(5);
    logic         align_i = 1'b0;
    logic         send_req = 1'b0;
    logic         ext_line = 1'b0;
    logic         line_in;
    logic         line_out, line_oe, ref_strobe, trig_sync, send_refused;
    logic [W-1:0] trig_lag;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   grid_e = 0;
    int   grid_p = 2;
    bit   timeout = 1'b0;
    exp_t sb[$];

    assign line_in = (line_oe & line_out) | ext_line;

    ptrig_retimer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .period_i(period_i),
        .align_i(align_i), .send_req(send_req), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe), .ref_strobe(ref_strobe),
        .trig_sync(trig_sync), .trig_lag(trig_lag), .send_refused(send_refused)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // monitor: pop and compare every released pulse
    always @(negedge clk) begin
        if (rst_n && trig_sync) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R5/R6 unexpected pulse", cyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.cyc, {e.tag, " R3 release cycle"}, cyc, e.cyc);
                chk(int'(trig_lag) == e.lag, {e.tag, " R4 lag"}, int'(trig_lag), e.lag);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push expectation for an edge detected in cycle d
    task automatic expect_edge(input int d, input string tag);
        exp_t e;
        int s;
        s = grid_e;
        while (s <= d) s += grid_p;
        e.cyc = s + 1;
        e.lag = s - d;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_align(input int p);
        period_i = W'(p);
        align_i  = 1'b1;
        grid_e   = cyc + 1;
        grid_p   = (p < 2) ? 2 : p;
        wait_cyc(1);
        align_i  = 1'b0;
    endtask

    task automatic ext_pulse(input int len, input bit expect_it, input string tag);
        if (expect_it) expect_edge(cyc + 2, tag);
        ext_line = 1'b1;
        wait_cyc(len);
        ext_line = 1'b0;
        wait_cyc(1);
    endtask

    task automatic drain(input string tag);
        wait_cyc(3 * grid_p + 4);
        chk(sb.size() == 0, {tag, " missing pulse"}, sb.size(), 0);
    endtask

    task automatic run_all();
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // reset state, R1
        chk(ref_strobe == 1'b0 || ref_strobe == 1'b1, "R1 strobe known", ref_strobe, 1);
        chk(trig_sync == 1'b0, "R3 reset trig", trig_sync, 0);
        chk(line_oe == 1'b0, "R11 reset oe", line_oe, 0);
        chk(send_refused == 1'b0, "R10 reset refused", send_refused, 0);

        // R1/R2 strobe grid after alignment
        do_align(5);
        for (int i = 0; i < 15; i++) begin
            chk(ref_strobe == (((cyc - grid_e) % grid_p) == 0), "R1 R2 strobe grid",
                ref_strobe, ((cyc - grid_e) % grid_p) == 0);
            wait_cyc(1);
        end

        // R3/R4 every phase, including detection on a strobe cycle
        for (int ph = 0; ph < 5; ph++) begin
            do_align(5);
            wait_cyc(ph);
            ext_pulse(1, 1'b1, "R3 phase");
            drain("R3");
        end

        // R6 held level gives one trigger
        do_align(4);
        ext_pulse(20, 1'b1, "R6 level");
        drain("R6");

        // R5 second edge while held is dropped
        do_align(12);
        ext_pulse(1, 1'b1, "R5 first");
        ext_pulse(1, 1'b0, "R5 second");
        drain("R5");

        // R7 clamp of small periods
        do_align(1);
        for (int i = 0; i < 8; i++) begin
            chk(ref_strobe == (((cyc - grid_e) % 2) == 0), "R7 clamp 1", ref_strobe,
                ((cyc - grid_e) % 2) == 0);
            wait_cyc(1);
        end
        do_align(0);
        for (int i = 0; i < 6; i++) begin
            chk(ref_strobe == (((cyc - grid_e) % 2) == 0), "R7 clamp 0", ref_strobe,
                ((cyc - grid_e) % 2) == 0);
            wait_cyc(1);
        end

        // R8 period change waits for the wrap
        do_align(6);
        begin
            int e0;
            e0 = grid_e;
            wait_cyc(2);
            period_i = W'(3);
            for (int i = 0; i < 11; i++) begin
                int k;
                bit ex;
                k = cyc - e0;
                ex = (k == 6) || (k == 9) || (k == 12);
                chk(ref_strobe == ex, "R8 period change", ref_strobe, ex);
                wait_cyc(1);
            end
        end

        // R9/R10/R11 master launch in star wiring
        is_master = 1'b1;
        do_align(8);
        wait_cyc(1);
        chk(line_oe == 1'b1, "R11 star oe", line_oe, 1);
        begin
            int c;
            c = cyc;
            expect_edge(c + 3, "R9 launch");
            send_req = 1'b1;
            wait_cyc(1);
            chk(line_out == 1'b1, "R9 drive start", line_out, 1);
            chk(send_refused == 1'b0, "R9 accepted", send_refused, 0);
            wait_cyc(1);   // request still high in drive: refused (busy)
            chk(send_refused == 1'b1, "R10 busy refuse", send_refused, 1);
            send_req = 1'b0;
            wait_cyc(1);
            chk(line_out == 1'b1, "R9 drive hold", line_out, 1);
            wait_cyc(1);
            chk(line_out == 1'b0, "R9 drive end", line_out, 0);
            send_req = 1'b1;   // edge is held now: refused (star)
            wait_cyc(1);
            send_req = 1'b0;
            chk(send_refused == 1'b1, "R10 pending refuse", send_refused, 1);
            chk(line_out == 1'b0, "R10 no drive", line_out, 0);
            wait_cyc(1);
            chk(line_out == 1'b0, "R10 no drive later", line_out, 0);
        end
        drain("R9");

        // R10/R11 non-master
        is_master = 1'b0;
        wait_cyc(1);
        chk(line_oe == 1'b0, "R11 slave oe", line_oe, 0);
        send_req = 1'b1;
        wait_cyc(1);
        send_req = 1'b0;
        chk(send_refused == 1'b1, "R10 slave refuse", send_refused, 1);
        chk(line_out == 1'b0, "R10 slave no drive", line_out, 0);
        drain("R10");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule